// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes each instruction in one clock period. On every cycle it fetches the word at the program counter from a small internal instruction store, decodes it and reads two operands from a 32-entry register file. It then computes a result in the ALU, optionally touches a small internal data store, and on the next rising edge commits the register write, the memory write and the new program counter together. The instruction set covers register-register add, subtract, AND, OR and signed set-on-less-than, plus OR with a zero-extended immediate, word load, word store and branch-if-equal.

Decoding is split into two levels. A main decoder looks only at the opcode and produces the datapath steering plus a 3-bit ALU class. A local ALU decoder turns that class, together with the function field for register-register operations, into the 3-bit ALU operation. A separate next-PC unit takes the ALU zero flag and the branch control and picks either the sequential address or the branch target.

The instruction store is filled through a plain load port while reset is held. Commit activity (register write, memory write) and the PC are brought out as plain status pins. There is no streaming data at the edge, so no valid/ready handshake is used and there is no back-pressure.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the PC becomes 0; after reset releases, the first instruction executed is the one at address 0.
- R2: A register-register instruction (opcode 000000) with funct 100000 (add), 100010 (subtract), 100100 (AND) or 100101 (OR) writes the result of rs op rt to register rd (bits [15:11]); rs is bits [25:21], rt bits [20:16].
- R3: Register-register funct 101010 writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise; bits [31:1] of the result are always 0.
- R4: Opcode 001101 writes rs OR the zero-extended 16-bit immediate (bits [15:0]) to register rt.
- R5: Opcode 100011 writes to rt the data word stored at address rs + sign-extended immediate; the store is word-indexed by address bits [DMEM_AW+1:2].
- R6: Opcode 101011 writes rt to the data word at address rs + sign-extended immediate and writes no register; no instruction writes both a register and memory.
- R7: Opcode 000100 compares rs and rt by subtraction; when equal the next PC is PC+4 + (sign-extended immediate << 2), otherwise PC+4; it writes neither registers nor memory.
- R8: Register 0 always reads as zero; writes aimed at it have no effect.
- R9: Any opcode other than the five above writes neither a register nor memory and advances the PC by 4.
- R10: Every instruction other than a taken branch sets the next PC to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Instruction-store load strobe |
| ld_addr | input | IMEM_AW | Word index for an instruction-store load |
| ld_data | input | 32 | Instruction word to load |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word fetched at the PC |
| rf_we_o | output | 1 | Decoded register write enable for this cycle |
| rf_waddr_o | output | 5 | Register write destination |
| rf_wdata_o | output | 32 | Register write-back value |
| dm_we_o | output | 1 | Data-store write enable for this cycle |
| dm_addr_o | output | 32 | Data address (ALU result) |
| dm_wdata_o | output | 32 | Data to store (second register read) |

## Verification
The bench builds the core with its default sizes, 64-word instruction and data stores, which keeps both stores small enough that random load/store addresses and branch offsets wrap around the word index and revisit earlier words. Random programs over only eight registers make reads of freshly written values, register 0 as destination, and equal operands for branches frequent. A directed program adds the signed compare on negative values, the full 16-bit zero-extended immediate, a store followed by a load of the same word and an unknown opcode.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  localparam logic [2:0] CLS_FUNCT = 3'b100;
  localparam logic [2:0] CLS_OR    = 3'b010;
  localparam logic [2:0] CLS_ADD   = 3'b000;
  localparam logic [2:0] CLS_SUB   = 3'b001;

  typedef struct packed {
    logic       legal;
    logic       reg_we;
    logic       dst_rd;
    logic       b_imm;
    logic       zext;
    logic       mem_we;
    logic       mem_to_reg;
    logic       branch;
    logic [2:0] alu_cls;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic [2:0] alu_op
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OPC_REG: begin
        ctrl.legal = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1;
        ctrl.alu_cls = CLS_FUNCT;
      end
      OPC_ORI: begin
        ctrl.legal = 1'b1; ctrl.reg_we = 1'b1; ctrl.b_imm = 1'b1;
        ctrl.zext = 1'b1; ctrl.alu_cls = CLS_OR;
      end
      OPC_LOAD: begin
        ctrl.legal = 1'b1; ctrl.reg_we = 1'b1; ctrl.b_imm = 1'b1;
        ctrl.mem_to_reg = 1'b1; ctrl.alu_cls = CLS_ADD;
      end
      OPC_STOR: begin
        ctrl.legal = 1'b1; ctrl.mem_we = 1'b1; ctrl.b_imm = 1'b1;
        ctrl.alu_cls = CLS_ADD;
      end
      OPC_BEQ: begin
        ctrl.legal = 1'b1; ctrl.branch = 1'b1; ctrl.alu_cls = CLS_SUB;
      end
      default: ctrl = '0;
    endcase
  end

  // second level: class plus function field
  always_comb begin
    unique case (ctrl.alu_cls)
      CLS_FUNCT: begin
        unique case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
      CLS_OR:  alu_op = ALU_OR;
      CLS_SUB: alu_op = ALU_SUB;
      default: alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      op,
  output logic [XLEN-1:0] res,
  output logic            zero
);
  logic [XLEN-1:0] diff;
  logic            less;

  assign diff = a - b;
  // signed compare from sign bits and the difference
  assign less = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

  always_comb begin
    unique case (op)
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_ADD: res = a + b;
      ALU_SUB: res = diff;
      ALU_SLT: res = {{(XLEN-1){1'b0}}, less};
      default: res = '0;
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ra_a,
  input  logic [REG_AW-1:0] ra_b,
  output logic [XLEN-1:0]   rd_a,
  output logic [XLEN-1:0]   rd_b,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            branch,
  input  logic            zero,
  input  logic [XLEN-1:0] imm_sx,
  output logic [XLEN-1:0] pc
);
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] tgt_pc;
  logic            taken;

  assign seq_pc = pc + XLEN'(4);
  assign tgt_pc = seq_pc + {imm_sx[XLEN-3:0], 2'b00};
  assign taken  = branch & zero;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= taken ? tgt_pc : seq_pc;
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    !(branch && zero) |=> pc == $past(pc) + XLEN'(4)); // R10
  AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst)
    (branch && zero) |=> pc == $past(pc) + XLEN'(4) + {$past(imm_sx[XLEN-3:0]), 2'b00}); // R7
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    instr_o,
  output logic               rf_we_o,
  output logic [REG_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               dm_we_o,
  output logic [XLEN-1:0]    dm_addr_o,
  output logic [XLEN-1:0]    dm_wdata_o
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0]   pc, instr, rs_val, rt_val, imm_x, imm_sx, alu_b, alu_res, ld_word;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, dst;
  logic [15:0]       f_imm;
  logic [2:0]        alu_op;
  logic              alu_zero;
  ctrl_t             ctrl;

  always_ff @(posedge clk) begin
    if (ld_we) imem[ld_addr] <= ld_data;
  end

  assign instr = imem[pc[IMEM_AW+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  assign dst = ctrl.dst_rd ? f_rd : f_rt;

  sc_regfile u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .we   (ctrl.reg_we),
    .wa   (dst),
    .wd   (rf_wdata_o)
  );

  assign imm_sx = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign imm_x  = ctrl.zext ? {{(XLEN-16){1'b0}}, f_imm} : imm_sx;
  assign alu_b  = ctrl.b_imm ? imm_x : rt_val;

  sc_alu u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .res  (alu_res),
    .zero (alu_zero)
  );

  assign ld_word = dmem[alu_res[DMEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (ctrl.mem_we) begin
      dmem[alu_res[DMEM_AW+1:2]] <= rt_val;
    end
  end

  sc_next_pc u_npc (
    .clk    (clk),
    .rst    (rst),
    .branch (ctrl.branch),
    .zero   (alu_zero),
    .imm_sx (imm_sx),
    .pc     (pc)
  );

  assign pc_o       = pc;
  assign instr_o    = instr;
  assign rf_we_o    = ctrl.reg_we;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = ctrl.mem_to_reg ? ld_word : alu_res;
  assign dm_we_o    = ctrl.mem_we;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = rt_val;

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(rf_we_o && dm_we_o)); // R6
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl.legal |-> !rf_we_o && !dm_we_o && !ctrl.branch); // R9
  AST_SLT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (alu_op == ALU_SLT) |-> rf_wdata_o[XLEN-1:1] == '0); // R3
  AST_RESET_PC: assert property (@(posedge clk)
    rst |=> pc_o == '0); // R1
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IAW = 6;
  localparam int DAW = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_we = 1'b0;
  logic [IAW-1:0] ld_addr = '0;
  logic [31:0]    ld_data = '0;
  logic [31:0]    pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]     rf_waddr_o;
  logic           rf_we_o, dm_we_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_rf [32];
  logic [31:0] m_dm [1<<DAW];
  logic [31:0] m_im [1<<IAW];
  logic [31:0] m_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wdata_o(dm_wdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s pc=%08h actual=%08h expected=%08h", tag, m_pc, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // load the program while reset is held, then release
  task automatic run_program(input int cycles);
    rst = 1'b1;
    for (int i = 0; i < (1<<IAW); i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = IAW'(i); ld_data = m_im[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    chk("R1", pc_o, 32'h0);
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < (1<<DAW); i++) m_dm[i] = '0;
    m_pc = '0;
    rst = 1'b0;
    #1;
    chk("R1", pc_o, 32'h0);
    for (int c = 0; c < cycles; c++) step();
  endtask

  task automatic step();
    logic [31:0] ins, a, b, sx, res, nxt, wv;
    logic [5:0]  op, fn;
    int          rs, rt, rd, wa;
    bit          ewe, edm;
    string       tag, ptag;
    ins = m_im[m_pc[IAW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = m_rf[rs]; b = m_rf[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    ewe = 0; edm = 0; wa = 0; wv = '0; res = '0;
    nxt = m_pc + 32'd4; ptag = "R10";
    case (op)
      6'b000000: begin
        ewe = 1; wa = rd; tag = "R2";
        case (fn)
          6'b100010: wv = a - b;
          6'b100100: wv = a & b;
          6'b100101: wv = a | b;
          6'b101010: begin wv = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
          default:   wv = a + b;
        endcase
      end
      6'b001101: begin ewe = 1; wa = rt; wv = a | {16'h0, ins[15:0]}; tag = "R4"; end
      6'b100011: begin res = a + sx; ewe = 1; wa = rt; wv = m_dm[res[DAW+1:2]]; tag = "R5"; end
      6'b101011: begin res = a + sx; edm = 1; tag = "R6"; end
      6'b000100: begin
        tag = "R7"; ptag = "R7";
        if (a == b) nxt = m_pc + 32'd4 + {sx[29:0], 2'b00};
      end
      default: begin tag = "R9"; ptag = "R9"; end
    endcase
    chk(tag, instr_o, ins);
    chk(tag, {31'b0, rf_we_o}, {31'b0, ewe});
    if (ewe) begin
      chk(tag, {27'b0, rf_waddr_o}, 32'(wa));
      chk(((rs == 0 || rt == 0) && op == 6'b000000) ? "R8" : tag, rf_wdata_o, wv);
    end
    chk(tag, {31'b0, dm_we_o}, {31'b0, edm});
    if (edm) begin
      chk(tag, dm_addr_o, res);
      chk(tag, dm_wdata_o, b);
    end
    if (ewe && wa != 0) m_rf[wa] = wv;
    if (edm) m_dm[res[DAW+1:2]] = b;
    m_pc = nxt;
    @(negedge clk); #1;
    chk(ptag, pc_o, m_pc);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0011));
    // directed program
    for (int i = 0; i < (1<<IAW); i++) m_im[i] = enc_r(0, 0, 0, 6'b100000);
    m_im[0]  = enc_i(6'b001101, 0, 1, 16'hFFFF);         // R4 zero extension
    m_im[1]  = enc_i(6'b001101, 0, 0, 16'h0005);         // R8 write to r0
    m_im[2]  = enc_r(0, 0, 2, 6'b100000);                // R8 r0 reads zero
    m_im[3]  = enc_r(2, 1, 3, 6'b100010);                // negative difference
    m_im[4]  = enc_r(3, 1, 4, 6'b101010);                // R3 signed less: 1
    m_im[5]  = enc_r(1, 3, 5, 6'b101010);                // R3 not less: 0
    m_im[6]  = enc_i(6'b101011, 0, 3, 16'h0008);         // R6 store
    m_im[7]  = enc_i(6'b100011, 4, 6, 16'h0007);         // R5 load same word
    m_im[8]  = enc_i(6'b000100, 6, 3, 16'h0001);         // R7 taken
    m_im[9]  = enc_i(6'b001101, 0, 7, 16'h0001);         // skipped
    m_im[10] = 32'hFC00_FFFF;                            // R9 unknown opcode
    m_im[11] = enc_i(6'b000100, 0, 1, 16'h0005);         // R7 not taken
    m_im[12] = enc_r(1, 3, 7, 6'b100100);
    m_im[13] = enc_r(1, 3, 8, 6'b100101);
    m_im[14] = enc_i(6'b100011, 0, 9, 16'hFFFC);         // R5 negative offset wraps
    m_im[15] = enc_i(6'b000100, 0, 0, 16'hFFF0);         // R7 backward taken
    run_program(40);

    // random programs
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < (1<<IAW); i++) begin
        int k, rs, rt, rd;
        logic [5:0] fns [5];
        fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
        fns[3] = 6'b100101; fns[4] = 6'b101010;
        k = int'($urandom % 10);
        rs = int'($urandom % 8); rt = int'($urandom % 8); rd = int'($urandom % 8);
        case (k)
          0, 1, 2, 3, 4: m_im[i] = enc_r(rs, rt, rd, fns[$urandom % 5]);
          5: m_im[i] = enc_i(6'b001101, rs, rt, 16'($urandom));
          6: m_im[i] = enc_i(6'b100011, rs, rt, 16'($urandom));
          7: m_im[i] = enc_i(6'b101011, rs, rt, 16'($urandom));
          8: m_im[i] = enc_i(6'b000100, rs, rt,
                             (($urandom % 4) == 0) ? 16'hFFFD : 16'(1 + $urandom % 4));
          default: m_im[i] = {(($urandom % 2) == 0) ? 6'b111111 : 6'b000010, 26'($urandom)};
        endcase
      end
      run_program(600);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule